// File: doc/BRIEF.md
# Segmented virtual address translator

This block maps a 16-bit virtual address onto a physical address for a processor with a segmented memory manager. The top three address bits pick one of eight pages. Each page has a base register and a descriptor register in a bank selected by the requesting processor mode and by whether the access is an instruction or a data reference. The base register, plus the 7-bit block number, gives the upper physical bits, and the 6-bit displacement passes straight through. A top-level switch selects an 18-bit or a 22-bit physical space.

Every translated access is checked against the descriptor's 3-bit access code and its page length. The access code either allows the access, aborts it at once, or lets it through with a request for a trap at the end of the instruction. The length check is measured upward from block zero or downward from the top of the page. An access that is not aborted sets the page's accessed flag, and a write also sets its written flag. Software reads and writes base and descriptor registers over a simple register port. Writing either register of a page clears that page's two flags. With relocation switched off, the address goes through unchanged and nothing is checked.

A request is taken in one cycle and its result is registered, so the response appears on the cycle after the request.

Top module: `vaTranslator`

## Requirements
- R1: With relocation on and the wide (22-bit) space selected, a permitted access yields rspAddr = ((base + block) mod 2^16) * 64 + displacement. Block is reqAddr[12:6], displacement is reqAddr[5:0] and page is reqAddr[15:13].
- R2: With the narrow (18-bit) space selected, only base bits 11:0 are used and the sum is taken mod 2^12, so rspAddr[21:18] is zero.
- R3: With relocOn low, rspAddr equals reqAddr zero-extended, there is no abort and no trap, and no descriptor flag changes.
- R4: Descriptor access codes (bits 2:0) 0, 3 and 7 abort every access with reason code 3'b100 (page not usable).
- R5: Access code 1 aborts a write with reason 3'b001 (read-only) and passes a read with a trap request. Code 2 aborts a write with 3'b001 and passes a read with no trap.
- R6: Code 4 requests a trap on every access, code 5 on writes only, and code 6 never. None of these three aborts.
- R7: When descriptor bit 3 is clear, a block number greater than the length field (descriptor bits 14:8) aborts with reason 3'b010. A block number equal to the length passes.
- R8: When descriptor bit 3 is set, a block number less than the length aborts with reason 3'b010. A block number equal to the length passes.
- R9: An access-code abort takes precedence over a length abort. Exactly one reason bit is set on any abort, and an aborted access never carries a trap request.
- R10: A non-aborted read sets descriptor bit 7 (accessed). A non-aborted write sets bits 7 and 6 (accessed, written). An aborted access leaves the descriptor unchanged.
- R11: A register-port write to a page's base or descriptor register clears that page's descriptor bits 7 and 6. When such a write hits the same page as a same-cycle translation, the cleared flags win.
- R12: The bank is mode*2+space. Space is 1 only for a data reference whose mode has its data-space enable set (dspaceEn bit 2 for kernel mode 0, bit 1 for supervisor mode 1, bit 0 for user mode 3). regAddr is {bank[2:0], page[2:0], selectDescriptor}.
- R13: With relocation on, mode 2 aborts with reason 3'b100.
- R14: rspValid is high exactly on the cycle after a cycle with reqValid high. When rspValid is low, rspAbort and rspTrap are low. After reset, all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| relocOn | input | 1 | Relocation enable |
| wide22 | input | 1 | 1 selects the 22-bit physical space, 0 the 18-bit space |
| dspaceEn | input | 3 | Data-space enables: bit 2 kernel, bit 1 supervisor, bit 0 user |
| reqValid | input | 1 | Translation request |
| reqAddr | input | 16 | Virtual address |
| reqMode | input | 2 | Mode: 0 kernel, 1 supervisor, 3 user, 2 illegal |
| reqData | input | 1 | 1 for a data reference, 0 for an instruction reference |
| reqWrite | input | 1 | 1 for a write cycle |
| regWrite | input | 1 | Register port write strobe |
| regAddr | input | 7 | {bank, page, selectDescriptor} |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr, combinational |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspAddr | output | 22 | Physical address |
| rspAbort | output | 1 | Access aborted |
| rspAbortCode | output | 3 | One-hot reason: 100 not usable, 010 length, 001 read-only |
| rspTrap | output | 1 | End-of-instruction management trap request |

## Verification
The bench goes after base-plus-block wrap in both address widths. A design that forgot the 12-bit mask in the narrow space would leak base bits into rspAddr[21:18]. It drives each length check at the exact boundary block in both expansion directions, where an off-by-one comparison would abort a legal access or pass an illegal one. It walks every access code with reads and writes and reads the descriptors back. A design that set the flags on aborted accesses, or that left a trap asserted beside an abort, shows up there. It also collides a register write with a same-page translation in the same cycle, and switches data-space enables per mode. A wrong merge priority leaves stale flags. A wrong enable bit translates through the wrong bank and returns the other base.

// File: rtl/xlatePkg.sv
package xlatePkg;
  localparam int SEG_W  = 3;
  localparam int BLK_W  = 7;
  localparam int DISP_W = 6;
  localparam int MODE_W = 2;
  localparam int ACC_W  = 3;

  // Descriptor bit positions the checks and flag logic depend on
  localparam int PDR_LEN_LSB  = 8;
  localparam int PDR_ACC_BIT  = 7;
  localparam int PDR_WR_BIT   = 6;
  localparam int PDR_DOWN_BIT = 3;

  // One-hot abort reasons
  localparam logic [2:0] ABT_NONE   = 3'b000;
  localparam logic [2:0] ABT_UNUSED = 3'b100;
  localparam logic [2:0] ABT_LENGTH = 3'b010;
  localparam logic [2:0] ABT_RDONLY = 3'b001;

  localparam logic [MODE_W-1:0] MODE_KERN  = 2'd0;
  localparam logic [MODE_W-1:0] MODE_SUPER = 2'd1;
  localparam logic [MODE_W-1:0] MODE_BAD   = 2'd2;
  localparam logic [MODE_W-1:0] MODE_USER  = 2'd3;

  typedef struct packed {
    logic       passThru;
    logic       abort;
    logic [2:0] abortCode;
    logic       trap;
    logic       awSet;
    logic       wSet;
  } xlateStrobe_t;
endpackage

// File: rtl/xlateCtrl.sv
module xlateCtrl
  import xlatePkg::*;
#(
  parameter int BANK_W = MODE_W + 1
) (
  input  logic              relocOn,
  input  logic [2:0]        dspaceEn,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              reqData,
  input  logic              reqWrite,
  input  logic [BLK_W-1:0]  reqBlk,
  input  logic [ACC_W-1:0]  pdrAcc,
  input  logic              pdrDown,
  input  logic [BLK_W-1:0]  pdrLen,
  output logic [BANK_W-1:0] bank,
  output xlateStrobe_t      stb
);
  logic modeDataEn;
  logic spaceSel;
  logic lenFail;
  logic [2:0] accCode;
  logic accTrap;

  // Space folding: data references use the data bank only when enabled for that mode
  always_comb begin
    unique case (reqMode)
      MODE_KERN:  modeDataEn = dspaceEn[2];
      MODE_SUPER: modeDataEn = dspaceEn[1];
      MODE_USER:  modeDataEn = dspaceEn[0];
      default:    modeDataEn = 1'b0;
    endcase
    spaceSel = reqData & modeDataEn;
    bank     = BANK_W'({reqMode, spaceSel});
  end

  // Access-code decode
  always_comb begin
    accCode = ABT_NONE;
    accTrap = 1'b0;
    unique case (pdrAcc)
      3'd1: if (reqWrite) accCode = ABT_RDONLY; else accTrap = 1'b1;
      3'd2: if (reqWrite) accCode = ABT_RDONLY;
      3'd4: accTrap = 1'b1;
      3'd5: accTrap = reqWrite;
      3'd6: ;
      default: accCode = ABT_UNUSED;
    endcase
  end

  assign lenFail = pdrDown ? (reqBlk < pdrLen) : (reqBlk > pdrLen);

  always_comb begin
    stb = '0;
    if (!relocOn) begin
      stb.passThru = 1'b1;
    end else if (reqMode == MODE_BAD) begin
      stb.abort     = 1'b1;
      stb.abortCode = ABT_UNUSED;
    end else if (accCode != ABT_NONE) begin
      stb.abort     = 1'b1;
      stb.abortCode = accCode;
    end else if (lenFail) begin
      stb.abort     = 1'b1;
      stb.abortCode = ABT_LENGTH;
    end else begin
      stb.trap  = accTrap;
      stb.awSet = 1'b1;
      stb.wSet  = reqWrite;
    end
  end
endmodule

// File: rtl/xlateDatapath.sv
module xlateDatapath
  import xlatePkg::*;
#(
  parameter int PAR_W    = 16,
  parameter int NARROW_W = 12,
  parameter int PA_W     = PAR_W + DISP_W,
  parameter int VA_W     = SEG_W + BLK_W + DISP_W,
  parameter int BANK_W   = MODE_W + 1,
  parameter int REGA_W   = BANK_W + SEG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide22,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [BANK_W-1:0] bank,
  input  xlateStrobe_t      stb,
  input  logic              regWrite,
  input  logic [REGA_W-1:0] regAddr,
  input  logic [PAR_W-1:0]  regWdata,
  output logic [PAR_W-1:0]  regRdata,
  output logic [ACC_W-1:0]  pdrAcc,
  output logic              pdrDown,
  output logic [BLK_W-1:0]  pdrLen,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspAddr,
  output logic              rspAbort,
  output logic [2:0]        rspAbortCode,
  output logic              rspTrap
);
  localparam int ENT_W = BANK_W + SEG_W;
  localparam int NENT  = 1 << ENT_W;
  localparam logic [PAR_W-1:0] NARROW_MASK = PAR_W'((1 << NARROW_W) - 1);
  localparam logic [PAR_W-1:0] ACC_MASK    = PAR_W'(1) << PDR_ACC_BIT;
  localparam logic [PAR_W-1:0] AW_MASK     = ACC_MASK | (PAR_W'(1) << PDR_WR_BIT);

  logic [PAR_W-1:0] parMem [NENT];
  logic [PAR_W-1:0] pdrMem [NENT];

  logic [ENT_W-1:0]  hitIdx, regIdx;
  logic              regSelPdr;
  logic [PAR_W-1:0]  curPar, curPdr;
  logic [BLK_W-1:0]  blk;
  logic [DISP_W-1:0] disp;
  logic [PAR_W-1:0]  parEff, sum, sumEff;
  logic [PA_W-1:0]   xlAddr;

  assign hitIdx    = {bank, reqAddr[VA_W-1 -: SEG_W]};
  assign regIdx    = regAddr[REGA_W-1:1];
  assign regSelPdr = regAddr[0];

  assign curPar = parMem[hitIdx];
  assign curPdr = pdrMem[hitIdx];
  assign pdrAcc  = curPdr[ACC_W-1:0];
  assign pdrDown = curPdr[PDR_DOWN_BIT];
  assign pdrLen  = curPdr[PDR_LEN_LSB +: BLK_W];

  assign blk  = reqAddr[DISP_W +: BLK_W];
  assign disp = reqAddr[DISP_W-1:0];

  // Base plus block, masked to the narrow width when the small space is selected
  always_comb begin
    parEff = wide22 ? curPar : (curPar & NARROW_MASK);
    sum    = parEff + PAR_W'(blk);
    sumEff = wide22 ? sum : (sum & NARROW_MASK);
    xlAddr = stb.passThru ? PA_W'(reqAddr) : PA_W'({sumEff, disp});
  end

  assign regRdata = regSelPdr ? pdrMem[regIdx] : parMem[regIdx];

  // Register file: a port write beats a same-entry flag update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NENT; i++) begin
        parMem[i] <= '0;
        pdrMem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (regWrite && regIdx == ENT_W'(i)) begin
          if (regSelPdr) begin
            pdrMem[i] <= regWdata & ~AW_MASK;
          end else begin
            parMem[i] <= regWdata;
            pdrMem[i] <= pdrMem[i] & ~AW_MASK;
          end
        end else if (reqValid && stb.awSet && hitIdx == ENT_W'(i)) begin
          pdrMem[i] <= pdrMem[i] | (stb.wSet ? AW_MASK : ACC_MASK);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAddr      <= '0;
      rspAbort     <= 1'b0;
      rspAbortCode <= '0;
      rspTrap      <= 1'b0;
    end else begin
      rspValid     <= reqValid;
      rspAbort     <= reqValid & stb.abort;
      rspAbortCode <= reqValid ? stb.abortCode : 3'b000;
      rspTrap      <= reqValid & stb.trap;
      if (reqValid) rspAddr <= xlAddr;
    end
  end
endmodule

// File: rtl/vaTranslator.sv
module vaTranslator
  import xlatePkg::*;
#(
  parameter int PAR_W    = 16,
  parameter int NARROW_W = 12,
  parameter int VA_W     = SEG_W + BLK_W + DISP_W,
  parameter int PA_W     = PAR_W + DISP_W,
  parameter int BANK_W   = MODE_W + 1,
  parameter int REGA_W   = BANK_W + SEG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              relocOn,
  input  logic              wide22,
  input  logic [2:0]        dspaceEn,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              reqData,
  input  logic              reqWrite,
  input  logic              regWrite,
  input  logic [REGA_W-1:0] regAddr,
  input  logic [PAR_W-1:0]  regWdata,
  output logic [PAR_W-1:0]  regRdata,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspAddr,
  output logic              rspAbort,
  output logic [2:0]        rspAbortCode,
  output logic              rspTrap
);
  xlateStrobe_t      stb;
  logic [BANK_W-1:0] bank;
  logic [ACC_W-1:0]  pdrAcc;
  logic              pdrDown;
  logic [BLK_W-1:0]  pdrLen;

  xlateCtrl #(.BANK_W(BANK_W)) ctrl (
    .relocOn (relocOn),
    .dspaceEn(dspaceEn),
    .reqMode (reqMode),
    .reqData (reqData),
    .reqWrite(reqWrite),
    .reqBlk  (reqAddr[DISP_W +: BLK_W]),
    .pdrAcc  (pdrAcc),
    .pdrDown (pdrDown),
    .pdrLen  (pdrLen),
    .bank    (bank),
    .stb     (stb)
  );

  xlateDatapath #(
    .PAR_W(PAR_W), .NARROW_W(NARROW_W), .PA_W(PA_W),
    .VA_W(VA_W), .BANK_W(BANK_W), .REGA_W(REGA_W)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .wide22      (wide22),
    .reqValid    (reqValid),
    .reqAddr     (reqAddr),
    .bank        (bank),
    .stb         (stb),
    .regWrite    (regWrite),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .pdrAcc      (pdrAcc),
    .pdrDown     (pdrDown),
    .pdrLen      (pdrLen),
    .rspValid    (rspValid),
    .rspAddr     (rspAddr),
    .rspAbort    (rspAbort),
    .rspAbortCode(rspAbortCode),
    .rspTrap     (rspTrap)
  );
endmodule

// File: rtl/vaTranslatorChecker.sv
module vaTranslatorChecker #(
  parameter int VA_W = 16,
  parameter int PA_W = 22
) (
  input logic            clk,
  input logic            rstN,
  input logic            relocOn,
  input logic            reqValid,
  input logic [VA_W-1:0] reqAddr,
  input logic [1:0]      reqMode,
  input logic            rspValid,
  input logic [PA_W-1:0] rspAddr,
  input logic            rspAbort,
  input logic [2:0]      rspAbortCode,
  input logic            rspTrap
);
  a_r14_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r14_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r14_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspAbort && !rspTrap));

  a_r9_one_reason: assert property (@(posedge clk) disable iff (!rstN)
    rspAbort |-> ($countones(rspAbortCode) == 1));

  a_r9_no_reason_without_abort: assert property (@(posedge clk) disable iff (!rstN)
    !rspAbort |-> (rspAbortCode == 3'b000));

  a_r9_trap_excludes_abort: assert property (@(posedge clk) disable iff (!rstN)
    rspAbort |-> !rspTrap);

  a_r3_identity_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !relocOn) |=>
      (rspAddr == {{(PA_W-VA_W){1'b0}}, $past(reqAddr)} && !rspAbort && !rspTrap));

  a_r13_illegal_mode: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && relocOn && reqMode == 2'd2) |=> (rspAbort && rspAbortCode == 3'b100));
endmodule

bind vaTranslator vaTranslatorChecker #(.VA_W(VA_W), .PA_W(PA_W)) vaTranslatorChk (.*);

// File: tb/vaTranslator_test.sv
`timescale 1ns/1ps
module vaTranslator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        relocOn = 1'b0, wide22 = 1'b1;
  logic [2:0]  dspaceEn = 3'b000;
  logic        reqValid = 1'b0, reqData = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqMode = '0;
  logic        regWrite = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        rspValid, rspAbort, rspTrap;
  logic [21:0] rspAddr;
  logic [2:0]  rspAbortCode;

  int checkCnt = 0, failCnt = 0;
  int mPar [64];
  int mPdr [64];

  always #2.5 clk = ~clk;

  vaTranslator uut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference for one translation
  function automatic void predict(input logic [15:0] va, input logic [1:0] md, input bit dt, input bit wr,
                                  output logic [21:0] pa, output logic [2:0] code, output bit tr,
                                  output int ent, output bit upd);
    int blk, disp, seg, p, d, acc, len, sum, en;
    bit down;
    seg = va[15:13]; blk = va[12:6]; disp = va[5:0];
    pa = '0; code = 3'b000; tr = 0; ent = 0; upd = 0;
    if (!relocOn) begin pa = {6'b0, va}; return; end
    if (md == 2) begin code = 3'b100; return; end
    en = (md == 0) ? dspaceEn[2] : (md == 1) ? dspaceEn[1] : dspaceEn[0];
    ent = (md * 2 + ((dt && en != 0) ? 1 : 0)) * 8 + seg;
    p = mPar[ent]; d = mPdr[ent];
    acc = d & 7; down = d[3]; len = (d >> 8) & 127;
    case (acc)
      1: if (wr) code = 3'b001; else tr = 1;
      2: if (wr) code = 3'b001;
      4: tr = 1;
      5: tr = wr;
      6: ;
      default: code = 3'b100;
    endcase
    if (code == 0 && (down ? (blk < len) : (blk > len))) code = 3'b010;
    if (code != 0) begin tr = 0; return; end
    upd = 1;
    sum = (wide22 ? p : (p & 'hFFF)) + blk;
    sum = wide22 ? (sum & 'hFFFF) : (sum & 'hFFF);
    pa = 22'((sum << 6) | disp);
  endfunction

  task automatic compareRsp(input string req, input logic [21:0] pa, input logic [2:0] code, input bit tr);
    chk(req, "valid", 32'(rspValid), 1);
    chk(req, "abortCode", 32'(rspAbortCode), 32'(code));
    chk(req, "abort", 32'(rspAbort), 32'(code != 0));
    chk(req, "trap", 32'(rspTrap), 32'(tr));
    if (code == 0) chk(req, "addr", 32'(rspAddr), 32'(pa));
  endtask

  task automatic xl(input logic [15:0] va, input logic [1:0] md, input bit dt, input bit wr, input string req);
    logic [21:0] pa; logic [2:0] code; bit tr, upd; int ent;
    @(negedge clk);
    reqValid = 1; reqAddr = va; reqMode = md; reqData = dt; reqWrite = wr;
    predict(va, md, dt, wr, pa, code, tr, ent, upd);
    @(posedge clk); #1;
    reqValid = 0;
    compareRsp(req, pa, code, tr);
    if (upd) mPdr[ent] = mPdr[ent] | (wr ? 'hC0 : 'h80);
  endtask

  task automatic regWr(input int bank, input int page, input bit isPdr, input logic [15:0] val);
    int e;
    @(negedge clk);
    regWrite = 1; regAddr = {bank[2:0], page[2:0], isPdr}; regWdata = val;
    @(posedge clk); #1;
    regWrite = 0;
    e = bank * 8 + page;
    if (isPdr) mPdr[e] = val & ~'hC0;
    else begin mPar[e] = val; mPdr[e] = mPdr[e] & ~'hC0; end
  endtask

  task automatic rdChk(input int bank, input int page, input bit isPdr, input string req);
    int e;
    regAddr = {bank[2:0], page[2:0], isPdr};
    #1;
    e = bank * 8 + page;
    chk(req, isPdr ? "descriptor readback" : "base readback", 32'(regRdata),
        32'(isPdr ? mPdr[e] : mPar[e]) & 32'hFFFF);
  endtask

  task automatic idleChk();
    @(negedge clk);
    @(posedge clk); #1;
    chk("R14", "idle valid", 32'(rspValid), 0);
    chk("R14", "idle abort", 32'(rspAbort), 0);
  endtask

  initial begin : watchdog
    #1000000;
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [21:0] pa; logic [2:0] code; bit tr, upd; int ent;
    for (int i = 0; i < 64; i++) begin mPar[i] = 0; mPdr[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R14", "valid in reset", 32'(rspValid), 0);
    @(negedge clk) rstN = 1;
    #1;
    chk("R14", "valid after reset", 32'(rspValid), 0);
    rdChk(0, 0, 1, "R14");
    rdChk(5, 3, 0, "R14");

    // Kernel instruction bank (0): full-length pages, full access
    regWr(0, 0, 0, 16'h0100); regWr(0, 0, 1, 16'h7FC6);
    rdChk(0, 0, 1, "R11");
    regWr(0, 1, 0, 16'hF123); regWr(0, 1, 1, 16'h7F06);
    regWr(0, 4, 0, 16'hFFF0); regWr(0, 4, 1, 16'h7F06);

    // R3: relocation off
    xl(16'h1234, 0, 0, 1, "R3");
    rdChk(0, 0, 1, "R3");
    relocOn = 1;

    // R1: wide space
    xl(16'h016A, 0, 0, 0, "R1");
    xl(16'h2145, 0, 0, 0, "R1");
    xl(16'h8801, 0, 0, 0, "R1");    // base FFF0 + block 0x20 wraps
    // R2: narrow space
    wide22 = 0;
    xl(16'h2145, 0, 0, 0, "R2");
    xl(16'h8801, 0, 0, 0, "R2");
    wide22 = 1;
    idleChk();

    // R4/R5/R6 with R10 readback: every access code, read and write
    for (int a = 0; a < 8; a++) begin
      for (int w = 0; w < 2; w++) begin
        string tag;
        tag = (a == 0 || a == 3 || a == 7) ? "R4" : (a <= 2) ? "R5" : "R6";
        regWr(0, 2, 0, 16'h0040);
        regWr(0, 2, 1, 16'h7F00 | 16'(a));
        xl(16'h4000 | 16'(w * 16'h0105), 0, 0, w[0], tag);
        rdChk(0, 2, 1, "R10");
      end
    end

    // R7: upward length 10
    regWr(0, 3, 0, 16'h0200); regWr(0, 3, 1, 16'h0A06);
    xl(16'h6280, 0, 0, 0, "R7");    // block 10
    xl(16'h62C0, 0, 0, 0, "R7");    // block 11
    // R8: downward length 10
    regWr(0, 3, 1, 16'h0A0E);
    xl(16'h6280, 0, 0, 0, "R8");    // block 10
    xl(16'h6240, 0, 0, 0, "R8");    // block 9
    rdChk(0, 3, 1, "R10");

    // R9: precedence and trap suppression
    regWr(0, 3, 1, 16'h0A08);       // code 0, downward, block 9 fails length too
    xl(16'h6240, 0, 0, 0, "R9");
    regWr(0, 3, 1, 16'h0A0C);       // code 4 with length failure
    xl(16'h6240, 0, 0, 1, "R9");
    rdChk(0, 3, 1, "R9");

    // R11: register write collides with a same-page translation
    @(negedge clk);
    reqValid = 1; reqAddr = 16'h0040; reqMode = 0; reqData = 0; reqWrite = 1;
    regWrite = 1; regAddr = {3'd0, 3'd0, 1'b1}; regWdata = 16'h7F06;
    predict(16'h0040, 0, 0, 1, pa, code, tr, ent, upd);
    @(posedge clk); #1;
    reqValid = 0; regWrite = 0;
    compareRsp("R11", pa, code, tr);
    mPdr[0] = 16'h7F06;
    rdChk(0, 0, 1, "R11");
    xl(16'h0000, 0, 0, 1, "R10");
    regWr(0, 0, 0, 16'h0100);
    rdChk(0, 0, 1, "R11");

    // R12: bank selection by mode and space
    regWr(6, 0, 0, 16'h0200); regWr(6, 0, 1, 16'h7F06);
    regWr(7, 0, 0, 16'h0300); regWr(7, 0, 1, 16'h7F06);
    regWr(2, 0, 0, 16'h0400); regWr(2, 0, 1, 16'h7F06);
    regWr(3, 0, 0, 16'h0500); regWr(3, 0, 1, 16'h7F06);
    xl(16'h0005, 3, 1, 0, "R12");
    dspaceEn = 3'b001;
    xl(16'h0005, 3, 1, 0, "R12");
    xl(16'h0005, 3, 0, 0, "R12");
    xl(16'h0005, 1, 1, 0, "R12");
    xl(16'h0005, 0, 1, 0, "R12");
    dspaceEn = 3'b010;
    xl(16'h0005, 1, 1, 0, "R12");
    dspaceEn = 3'b100;
    xl(16'h0005, 0, 1, 0, "R12");
    rdChk(7, 0, 1, "R12");

    // R13: illegal mode
    xl(16'h0005, 2, 0, 0, "R13");
    xl(16'h0005, 2, 1, 1, "R13");
    idleChk();

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule